// File: doc/BRIEF.md
# Per-Block Floating-Point Normalizer

This unit sits on the write-back path of a memory-based FFT engine. Each group of up to 64 complex results gets its own exponent, where a conventional design shares one exponent across a whole pass. The results of a group stream in with a start and an end marker and a group number. While they arrive, the unit parks them in one half of a two-bank sample store. It also keeps the smallest count of redundant sign bits seen across every real and imaginary part.

When the end marker arrives, that count becomes the group's 4-bit exponent. An all-zero group gets exponent 15 instead. The exponent is written into a 128-entry exponent table at the group's index. The parked samples are then replayed in arrival order, each part shifted left by the exponent, together with the exponent and the group number. Later passes read the table through a combinational read port to line up exponents before combining groups.

Because the store has two banks, one group can fill while the previous one drains. Full 64-sample groups can therefore arrive back to back with no idle cycle at either side.

Top module: `bfp_block_normalizer`

## Requirements
- R1: After reset, out_valid is low and every exponent table entry reads 0.
- R2: The samples of a group leave in the order they arrived. Each 11-bit two's complement part equals its input shifted left by the group's exponent.
- R3: The exponent of a non-zero group is the smallest redundant-sign-bit count over all real and imaginary parts of that group. For one part, the count is the number of consecutive bits below the MSB (bit 10), taken from bit 9 downward, that equal the MSB. Zero and -1 both count 10.
- R4: A group whose parts are all zero gets exponent 15, and its output parts are zero.
- R5: The shift never overflows. Every output part keeps its input sign and equals the input times 2 to the power of the exponent.
- R6: The table entry at in_blk, the index given with the end-marked sample, takes the exponent on the clock edge that ends the cycle after the end marker was accepted. tbl_rd_exp returns entry tbl_rd_idx combinationally from then on.
- R7: In the cycle right after an end marker, a read of that group's index returns the new exponent, not the old entry.
- R8: out_first is high only on a group's first output sample and out_last only on its final one. out_blk and out_exp stay constant over the group.
- R9: If the end-marked sample is presented in cycle c, out_first is high in cycle c+2. This holds both when the unit is idle and when 64-sample groups arrive back to back.
- R10: A group of any length from 1 to 64 produces exactly as many output samples as it received.
- R11: out_exp is always in the range 0 to 10, or 15.
- R12: in_first restarts a group: samples accepted since the last end marker are discarded and do not affect the exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_first | input | 1 | Sample opens a new group |
| in_last | input | 1 | Sample closes the group |
| in_blk | input | 7 | Group index, taken with the closing sample |
| in_re | input | 11 | Real part, two's complement |
| in_im | input | 11 | Imaginary part, two's complement |
| tbl_rd_idx | input | 7 | Exponent table read index |
| tbl_rd_exp | output | 4 | Exponent stored at tbl_rd_idx |
| out_valid | output | 1 | Output sample present |
| out_first | output | 1 | First sample of an output group |
| out_last | output | 1 | Final sample of an output group |
| out_blk | output | 7 | Group index of the output sample |
| out_exp | output | 4 | Exponent applied to the output group |
| out_re | output | 11 | Shifted real part |
| out_im | output | 11 | Shifted imaginary part |

## Verification
Two kinds of overlap can happen in one cycle. The first is the table write of a just-closed group and a table read of that same index. The bench reads an index whose old entry differs from the new exponent: the read returns the old value in the closing cycle and the new value in the next. The second is the replay of one group's last sample and the arrival of the next group's end marker. Three 64-sample groups are fed with no gap, and the bench checks that each group's first output lands exactly two cycles after its closing input, with no bubble between groups.

// File: rtl/bfpn_pkg.sv
package bfpn_pkg;
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_RUN  = 1'b1
    } drain_st_e;
endpackage

// File: rtl/bfpn_sign_count.sv
module bfpn_sign_count #(
    parameter int W  = 11,
    parameter int EW = 4
) (
    input  logic [W-1:0]  val,
    output logic [EW-1:0] cnt
);
    logic [EW-1:0] cnt_v;
    logic          run_v;

    always_comb begin
        cnt_v = '0;
        run_v = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (run_v && (val[i] == val[W-1])) begin
                cnt_v = cnt_v + 1'b1;
            end else begin
                run_v = 1'b0;
            end
        end
        cnt = cnt_v;
    end
endmodule

// File: rtl/bfpn_sample_store.sv
module bfpn_sample_store #(
    parameter int WORD_W = 22,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [1:0][WORD_W-1:0] bank_rd;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = mem[rd_addr];
    end

    assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/bfpn_exp_table.sv
module bfpn_exp_table #(
    parameter int NUM_ENT = 128,
    parameter int EW      = 4,
    localparam int IW     = $clog2(NUM_ENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [EW-1:0] wd,
    input  logic [IW-1:0] ra,
    output logic [EW-1:0] rd
);
    logic [NUM_ENT-1:0][EW-1:0] tab_d;
    logic [NUM_ENT-1:0][EW-1:0] tab_q;

    always_comb begin
        tab_d = tab_q;
        if (we) begin
            tab_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    // Pending write is forwarded to a read of the same entry.
    assign rd = (we && (ra == wa)) ? wd : tab_q[ra];
endmodule

// File: rtl/bfp_block_normalizer.sv
module bfp_block_normalizer #(
    parameter int DATA_W  = 11,
    parameter int BLK_LEN = 64,
    parameter int NUM_BLK = 128,
    parameter int EXP_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic                       in_last,
    input  logic [$clog2(NUM_BLK)-1:0] in_blk,
    input  logic [DATA_W-1:0]          in_re,
    input  logic [DATA_W-1:0]          in_im,
    input  logic [$clog2(NUM_BLK)-1:0] tbl_rd_idx,
    output logic [EXP_W-1:0]           tbl_rd_exp,
    output logic                       out_valid,
    output logic                       out_first,
    output logic                       out_last,
    output logic [$clog2(NUM_BLK)-1:0] out_blk,
    output logic [EXP_W-1:0]           out_exp,
    output logic [DATA_W-1:0]          out_re,
    output logic [DATA_W-1:0]          out_im
);
    import bfpn_pkg::*;

    localparam int AW = $clog2(BLK_LEN);
    localparam int IW = $clog2(NUM_BLK);
    localparam logic [EXP_W-1:0] MAX_SHIFT = EXP_W'(DATA_W - 1);
    localparam logic [EXP_W-1:0] ZERO_EXP  = '1;

    typedef struct packed {
        logic                      wr_bank;
        logic [AW-1:0]             wr_ptr;
        logic [EXP_W-1:0]          run_min;
        logic                      run_nz;
        logic [1:0]                full;
        logic [1:0][AW-1:0]        m_len;
        logic [1:0][EXP_W-1:0]     m_exp;
        logic [1:0][IW-1:0]        m_blk;
        logic                      tbl_we;
        logic [IW-1:0]             tbl_wa;
        logic [EXP_W-1:0]          tbl_wd;
        drain_st_e                 st;
        logic                      rd_bank;
        logic [AW-1:0]             rd_ptr;
        logic                      o_valid;
        logic                      o_first;
        logic                      o_last;
        logic [IW-1:0]             o_blk;
        logic [EXP_W-1:0]          o_exp;
        logic [DATA_W-1:0]         o_re;
        logic [DATA_W-1:0]         o_im;
    } ctl_t;

    ctl_t s_d;
    ctl_t s_q;

    logic [1:0][DATA_W-1:0] lane_val;
    logic [1:0][EXP_W-1:0]  lane_cnt;
    logic [EXP_W-1:0]       lane_min;
    logic [EXP_W-1:0]       base_min;
    logic                   base_nz;
    logic [EXP_W-1:0]       blk_min;
    logic                   blk_nz;
    logic [EXP_W-1:0]       blk_exp;
    logic [AW-1:0]          cur_ptr;
    logic                   wr_en;
    logic [2*DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]      st_re;
    logic [DATA_W-1:0]      st_im;

    // Signals brought out for the bound checker.
    logic                   tbl_we_w;
    logic [IW-1:0]          tbl_wa_w;
    logic [EXP_W-1:0]       tbl_wd_w;

    assign lane_val = {in_im, in_re};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        bfpn_sign_count #(
            .W  (DATA_W),
            .EW (EXP_W)
        ) u_cnt (
            .val (lane_val[g]),
            .cnt (lane_cnt[g])
        );
    end

    bfpn_sample_store #(
        .WORD_W (2 * DATA_W),
        .DEPTH  (BLK_LEN)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (s_q.wr_bank),
        .wr_addr (cur_ptr),
        .wr_data ({in_im, in_re}),
        .rd_bank (s_q.rd_bank),
        .rd_addr (s_q.rd_ptr),
        .rd_data (rd_word)
    );

    bfpn_exp_table #(
        .NUM_ENT (NUM_BLK),
        .EW      (EXP_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (s_q.tbl_we),
        .wa    (s_q.tbl_wa),
        .wd    (s_q.tbl_wd),
        .ra    (tbl_rd_idx),
        .rd    (tbl_rd_exp)
    );

    assign st_re = rd_word[DATA_W-1:0];
    assign st_im = rd_word[2*DATA_W-1:DATA_W];

    always_comb begin
        s_d           = s_q;
        s_d.tbl_we    = 1'b0;
        s_d.o_valid   = 1'b0;
        s_d.o_first   = 1'b0;
        s_d.o_last    = 1'b0;
        wr_en         = 1'b0;

        // Collection side: running minimum of sign-bit counts.
        cur_ptr  = in_first ? '0 : s_q.wr_ptr;
        base_min = in_first ? MAX_SHIFT : s_q.run_min;
        base_nz  = in_first ? 1'b0 : s_q.run_nz;
        lane_min = (lane_cnt[0] < lane_cnt[1]) ? lane_cnt[0] : lane_cnt[1];
        blk_min  = (lane_min < base_min) ? lane_min : base_min;
        blk_nz   = base_nz | (|in_re) | (|in_im);
        blk_exp  = blk_nz ? blk_min : ZERO_EXP;

        if (in_valid) begin
            wr_en = 1'b1;
            if (in_last) begin
                s_d.full[s_q.wr_bank]  = 1'b1;
                s_d.m_len[s_q.wr_bank] = cur_ptr;
                s_d.m_exp[s_q.wr_bank] = blk_exp;
                s_d.m_blk[s_q.wr_bank] = in_blk;
                s_d.tbl_we             = 1'b1;
                s_d.tbl_wa             = in_blk;
                s_d.tbl_wd             = blk_exp;
                s_d.wr_bank            = ~s_q.wr_bank;
                s_d.wr_ptr             = '0;
                s_d.run_min            = MAX_SHIFT;
                s_d.run_nz             = 1'b0;
            end else begin
                s_d.wr_ptr  = cur_ptr + 1'b1;
                s_d.run_min = blk_min;
                s_d.run_nz  = blk_nz;
            end
        end

        // Replay side: one shifted sample per cycle.
        case (s_q.st)
            DR_RUN: begin
                s_d.o_valid = 1'b1;
                s_d.o_first = (s_q.rd_ptr == '0);
                s_d.o_last  = (s_q.rd_ptr == s_q.m_len[s_q.rd_bank]);
                s_d.o_blk   = s_q.m_blk[s_q.rd_bank];
                s_d.o_exp   = s_q.m_exp[s_q.rd_bank];
                s_d.o_re    = st_re << s_q.m_exp[s_q.rd_bank];
                s_d.o_im    = st_im << s_q.m_exp[s_q.rd_bank];
                if (s_q.rd_ptr == s_q.m_len[s_q.rd_bank]) begin
                    s_d.full[s_q.rd_bank] = 1'b0;
                    s_d.rd_bank           = ~s_q.rd_bank;
                    s_d.rd_ptr            = '0;
                    s_d.st                = s_d.full[~s_q.rd_bank] ? DR_RUN : DR_IDLE;
                end else begin
                    s_d.rd_ptr = s_q.rd_ptr + 1'b1;
                end
            end
            default: begin
                if (s_d.full[s_q.rd_bank]) begin
                    s_d.st     = DR_RUN;
                    s_d.rd_ptr = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.run_min <= MAX_SHIFT;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.o_valid;
    assign out_first = s_q.o_first;
    assign out_last  = s_q.o_last;
    assign out_blk   = s_q.o_blk;
    assign out_exp   = s_q.o_exp;
    assign out_re    = s_q.o_re;
    assign out_im    = s_q.o_im;

    assign tbl_we_w  = s_q.tbl_we;
    assign tbl_wa_w  = s_q.tbl_wa;
    assign tbl_wd_w  = s_q.tbl_wd;
endmodule

// File: rtl/bfpn_checker.sv
module bfpn_checker #(
    parameter int DATA_W = 11,
    parameter int IW     = 7,
    parameter int EXP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic [IW-1:0]     in_blk,
    input logic [IW-1:0]     tbl_rd_idx,
    input logic [EXP_W-1:0]  tbl_rd_exp,
    input logic              out_valid,
    input logic              out_first,
    input logic              out_last,
    input logic [IW-1:0]     out_blk,
    input logic [EXP_W-1:0]  out_exp,
    input logic [DATA_W-1:0] out_re,
    input logic [DATA_W-1:0] out_im,
    input logic              tbl_we,
    input logic [IW-1:0]     tbl_wa,
    input logic [EXP_W-1:0]  tbl_wd
);
    localparam logic [EXP_W-1:0] ZERO_EXP = '1;

    a_r11_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_exp <= EXP_W'(DATA_W - 1)) || (out_exp == ZERO_EXP)));

    a_r4_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_exp == ZERO_EXP)) |-> ((out_re == '0) && (out_im == '0)));

    a_r8_block_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && !out_first && $stable(out_blk) && $stable(out_exp)));

    a_r6_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (tbl_we && (tbl_wa == $past(in_blk))));

    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && (tbl_rd_idx == tbl_wa)) |-> (tbl_rd_exp == tbl_wd));

    a_r1_first_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> out_valid);
endmodule

bind bfp_block_normalizer bfpn_checker #(
    .DATA_W (DATA_W),
    .IW     ($clog2(NUM_BLK)),
    .EXP_W  (EXP_W)
) u_bfpn_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_blk     (in_blk),
    .tbl_rd_idx (tbl_rd_idx),
    .tbl_rd_exp (tbl_rd_exp),
    .out_valid  (out_valid),
    .out_first  (out_first),
    .out_last   (out_last),
    .out_blk    (out_blk),
    .out_exp    (out_exp),
    .out_re     (out_re),
    .out_im     (out_im),
    .tbl_we     (tbl_we_w),
    .tbl_wa     (tbl_wa_w),
    .tbl_wd     (tbl_wd_w)
);

// File: tb/bfp_block_normalizer_tb_top.sv
module bfp_block_normalizer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic        in_last = 1'b0;
    logic [6:0]  in_blk = '0;
    logic [10:0] in_re = '0;
    logic [10:0] in_im = '0;
    logic [6:0]  tbl_rd_idx = '0;
    logic [3:0]  tbl_rd_exp;
    logic        out_valid;
    logic        out_first;
    logic        out_last;
    logic [6:0]  out_blk;
    logic [3:0]  out_exp;
    logic [10:0] out_re;
    logic [10:0] out_im;

    always #10 clk = ~clk;

    bfp_block_normalizer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_blk(in_blk), .in_re(in_re), .in_im(in_im),
        .tbl_rd_idx(tbl_rd_idx), .tbl_rd_exp(tbl_rd_exp), .out_valid(out_valid),
        .out_first(out_first), .out_last(out_last), .out_blk(out_blk),
        .out_exp(out_exp), .out_re(out_re), .out_im(out_im)
    );

    // {blk[31:25], kind[24:22], amp[21:11], len[10:4], expected exponent[3:0]}
    localparam logic [31:0] VEC [12] = '{
        {7'd3,   3'd0, 11'sd100,   7'd64, 4'd3},
        {7'd5,   3'd1, -11'sd1024, 7'd64, 4'd0},
        {7'd7,   3'd2, 11'sd0,     7'd64, 4'd15},
        {7'd9,   3'd3, 11'sd1,     7'd64, 4'd9},
        {7'd11,  3'd4, 11'sd300,   7'd64, 4'd1},
        {7'd12,  3'd5, 11'sd0,     7'd64, 4'd10},
        {7'd127, 3'd1, 11'sd1023,  7'd10, 4'd0},
        {7'd0,   3'd3, -11'sd2,    7'd1,  4'd9},
        {7'd64,  3'd1, -11'sd513,  7'd64, 4'd0},
        {7'd40,  3'd1, 11'sd255,   7'd17, 4'd2},
        {7'd41,  3'd1, -11'sd256,  7'd5,  4'd2},
        {7'd3,   3'd0, 11'sd7,     7'd33, 4'd7}
    };

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int exp_re [2048];
    int exp_im [2048];
    int exp_e [2048];
    int exp_b [2048];
    bit exp_f [2048];
    bit exp_l [2048];
    int wrp = 0;
    int rdp = 0;
    int blk_len [64];
    int blk_lastcyc [64];
    int seq_in = 0;
    int seq_out = 0;
    int out_cnt = 0;
    int tab [128];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int gen_re(int kind, int amp, int k, int len);
        case (kind)
            0: return (k % 2 == 1) ? amp : -amp;
            1: return amp;
            3: return (k == len - 1) ? amp : 0;
            4: return ((k * 13) % (2 * amp + 1)) - amp;
            default: return 0;
        endcase
    endfunction

    function automatic int gen_im(int kind, int amp, int k);
        case (kind)
            0: return (k % 2 == 1) ? -amp : amp;
            4: return amp - ((k * 7) % (amp + 1));
            5: return -1;
            default: return 0;
        endcase
    endfunction

    task automatic send_block(input int blk, input int kind, input int amp, input int len, input int e);
        for (int k = 0; k < len; k++) begin
            int r = gen_re(kind, amp, k, len);
            int m = gen_im(kind, amp, k);
            exp_re[wrp] = (e == 15) ? 0 : r * (1 << e);
            exp_im[wrp] = (e == 15) ? 0 : m * (1 << e);
            exp_e[wrp]  = e;
            exp_b[wrp]  = blk;
            exp_f[wrp]  = (k == 0);
            exp_l[wrp]  = (k == len - 1);
            wrp++;
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = (k == len - 1);
            in_blk   = 7'(blk);
            in_re    = 11'(r);
            in_im    = 11'(m);
            if (k == len - 1) blk_lastcyc[seq_in] = cyc;
        end
        blk_len[seq_in] = len;
        seq_in++;
        tab[blk] = e;
    endtask

    task automatic idle_drain();
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        while (rdp != wrp) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rdp == wrp) begin
                chk(1'b0, "R2 unexpected output", 1, 0);
            end else begin
                chk(($signed(out_re) == exp_re[rdp]) && ($signed(out_im) == exp_im[rdp]),
                    "R2/R5 data re", $signed(out_re), exp_re[rdp]);
                chk(int'(out_exp) == exp_e[rdp], (exp_e[rdp] == 15) ? "R4 zero exponent" : "R3/R11 exponent",
                    int'(out_exp), exp_e[rdp]);
                chk((out_first == exp_f[rdp]) && (out_last == exp_l[rdp]) && (int'(out_blk) == exp_b[rdp]),
                    "R8 markers/blk", int'(out_blk), exp_b[rdp]);
                if (out_first) begin
                    out_cnt = 0;
                    chk(cyc == blk_lastcyc[seq_out] + 2, "R9 latency", cyc, blk_lastcyc[seq_out] + 2);
                end
                out_cnt++;
                if (out_last) begin
                    chk(out_cnt == blk_len[seq_out], "R10 count", out_cnt, blk_len[seq_out]);
                    seq_out++;
                end
                rdp++;
            end
        end
    end

    task automatic check_table(input string tag);
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            tbl_rd_idx = 7'(i);
            #1;
            chk(int'(tbl_rd_exp) == tab[i], tag, int'(tbl_rd_exp), tab[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) tab[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check_table("R1 table after reset");

        // Vector table walk.
        for (int v = 0; v < 12; v++) begin
            send_block(int'(VEC[v][31:25]), int'(VEC[v][24:22]), int'($signed(VEC[v][21:11])),
                       int'(VEC[v][10:4]), int'(VEC[v][3:0]));
            idle_drain();
        end

        // R7: read of index 3 (old 7) around a new closing of group 3 (new 0).
        tbl_rd_idx = 7'd3;
        send_block(3, 1, 1023, 8, 0);
        #1;
        chk(int'(tbl_rd_exp) == 7, "R7 old value in closing cycle", int'(tbl_rd_exp), 7);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #1;
        chk(int'(tbl_rd_exp) == 0, "R7 bypass next cycle", int'(tbl_rd_exp), 0);
        @(negedge clk);
        #1;
        chk(int'(tbl_rd_exp) == 0, "R6 value held", int'(tbl_rd_exp), 0);
        idle_drain();

        // R9: three full groups with no gap.
        send_block(20, 4, 500, 64, 1);
        send_block(21, 0, 33, 64, 4);
        send_block(22, 3, -300, 64, 1);
        idle_drain();

        // R12: partial group of -1024 abandoned, then a restart.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (k == 0);
            in_last  = 1'b0;
            in_re    = 11'h400;
            in_im    = 11'h400;
        end
        send_block(50, 3, 1, 4, 9);
        idle_drain();
        chk(seq_out == seq_in, "R12 groups out", seq_out, seq_in);

        check_table("R6 table readback");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", rdp, wrp);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule